// File: doc/BRIEF.md
# Minimal Serial Port Host Register File

This block is the host-side register file of a small serial port in the classic eight-register layout. A host reaches it through a 3-bit offset, an 8-bit data bus, a select strobe and a write flag. Received bytes come in on a valid/ready byte stream, and transmitted bytes leave on a single-cycle valid strobe. The transmitter is treated as always ready. There is one interrupt line.

Bit 7 of the line control register banks offsets 0 and 1. When it is set, those offsets reach the two divisor bytes, which are stored and read back. When it is clear, offset 0 is the receive/transmit holding register and offset 1 is the interrupt enable register. A receive flag and a transmit flag drive the interrupt line.

The interrupt identification register only reports whether any interrupt is pending. The line status register always shows an idle transmitter. The modem status register and offset 7 read as zero. The modem control register answers only a single loopback self-test pattern.

Top module: `serial_host_regs`

## Requirements
- R1: After reset, the enable, line control, modem control and divisor bytes are 0 and irq is 0. Offset 2 then reads 0x01, offset 5 reads 0x60, and offsets 1, 3, 4, 6 and 7 read 0x00.
- R2: While line control bit 7 is 1, offsets 0 and 1 write and read back the low and high divisor bytes. Accesses to them then neither pop a received byte nor strobe tx_valid.
- R3: While line control bit 7 is 0, a read of offset 0 returns rx_data and raises rx_ready in the same cycle if rx_valid is 1. If rx_valid is 0, the read returns 0x00 and rx_ready stays 0.
- R4: The receive flag sets at the clock edge of any cycle with rx_valid=1 and enable bit 0 set, unless that cycle is a read of offset 0 (bank clear). Such a read clears the flag instead. The flag never sets while enable bit 0 is 0.
- R5: A write of offset 0 with bank bit clear strobes tx_valid with tx_data equal to the written byte, and clears the transmit flag at that edge. If enable bit 1 was set at the write, the flag sets again at the following edge.
- R6: A write of offset 1 (bank clear) stores the enable byte. Bit 1 set raises the transmit flag. Bit 1 clear clears the flag and cancels a pending re-raise. Bit 0 set with rx_valid=1 raises the receive flag; otherwise the receive flag is cleared.
- R7: Offset 2 reads 0x00 when either flag is pending and 0x01 when none is.
- R8: Offset 5 reads bit 6 = 1, bit 5 = 1, bit 0 = rx_valid, and all other bits 0.
- R9: Offsets 6 and 7 read 0x00. Writes to offsets 2 and 7 change no register.
- R10: Offset 4 reads the modem control byte. A write of exactly 0x1A (loop bit 4 with 0x0A) makes it 0x9A. Any other written value leaves it unchanged.
- R11: irq is 1 exactly when the receive flag or the transmit flag is set.
- R12: Offset 3 reads back the last byte written to it. Offset 1 with bank bit clear reads back the enable byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when no read access) |
| rx_valid | input | 1 | A received byte is available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Received byte taken this cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is driven with data absent, with data present while the receive enable is off, and with data present while the enable is on and the same byte stays valid after a pop. Between them, these three patterns separate level-driven re-arming from one-shot setting. The transmit path is exercised three ways: writes with the transmit enable on (flag drops and then returns one edge later), writes with it off, and a write followed at once by disabling the enable (which shows whether the pending re-raise is cancelled). Bank-bit accesses, together with writes to the ignored offsets, show that decode keeps the divisor bytes separate from the data path.

// File: rtl/serial_host_regs.sv
module serial_host_regs #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter logic [DW-1:0] LOOP_KEY  = 8'h1A,
  parameter logic [DW-1:0] LOOP_ECHO = 8'h9A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          irq
);
  localparam logic [AW-1:0] A_HOLD = 3'd0, A_EN = 3'd1, A_ID = 3'd2, A_LINE = 3'd3;
  localparam logic [AW-1:0] A_MODEM = 3'd4, A_LSTAT = 3'd5, A_MSTAT = 3'd6, A_SPARE = 3'd7;
  localparam logic [DW-1:0] LSTAT_IDLE = 8'h60;

  logic [DW-1:0] en_q, line_q, modem_q, div_lo_q, div_hi_q;
  logic rx_flag, tx_flag, tx_arm;

  logic rd, wr, bank;
  assign rd   = bus_sel & ~bus_wr;
  assign wr   = bus_sel & bus_wr;
  assign bank = line_q[7];

  logic rd_hold, wr_hold, wr_en, wr_lo, wr_hi;
  assign rd_hold = rd & (bus_addr == A_HOLD) & ~bank;
  assign wr_hold = wr & (bus_addr == A_HOLD) & ~bank;
  assign wr_en   = wr & (bus_addr == A_EN) & ~bank;
  assign wr_lo   = wr & (bus_addr == A_HOLD) & bank;
  assign wr_hi   = wr & (bus_addr == A_EN) & bank;

  assign rx_ready = rd_hold & rx_valid;
  assign tx_valid = wr_hold;
  assign tx_data  = bus_wdata;
  assign irq      = rx_flag | tx_flag;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_HOLD:  bus_rdata = bank ? div_lo_q : (rx_valid ? rx_data : '0);
        A_EN:    bus_rdata = bank ? div_hi_q : en_q;
        A_ID:    bus_rdata = {{(DW-1){1'b0}}, ~irq};
        A_LINE:  bus_rdata = line_q;
        A_MODEM: bus_rdata = modem_q;
        A_LSTAT: bus_rdata = LSTAT_IDLE | {{(DW-1){1'b0}}, rx_valid};
        A_MSTAT: bus_rdata = '0;
        A_SPARE: bus_rdata = '0;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      line_q   <= '0;
      modem_q  <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      if (wr_en) en_q <= bus_wdata;
      if (wr_lo) div_lo_q <= bus_wdata;
      if (wr_hi) div_hi_q <= bus_wdata;
      if (wr && bus_addr == A_LINE) line_q <= bus_wdata;
      if (wr && bus_addr == A_MODEM && bus_wdata == LOOP_KEY) modem_q <= LOOP_ECHO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_flag <= 1'b0;
    end else if (wr_en) begin
      rx_flag <= bus_wdata[0] & rx_valid;
    end else if (rd_hold) begin
      rx_flag <= 1'b0;
    end else if (rx_valid && en_q[0]) begin
      rx_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flag <= 1'b0;
      tx_arm  <= 1'b0;
    end else if (wr_en) begin
      tx_flag <= bus_wdata[1];
      tx_arm  <= 1'b0;
    end else if (wr_hold) begin
      tx_flag <= 1'b0;
      tx_arm  <= en_q[1];
    end else begin
      if (tx_arm) tx_flag <= 1'b1;
      tx_arm <= 1'b0;
    end
  end
endmodule

module serial_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       irq,
  input logic [7:0] line_q,
  input logic [7:0] modem_q,
  input logic       tx_flag
);
  // R7
  iir_reflects_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd2) |-> bus_rdata == {7'b0, ~irq});
  // R8
  lsr_idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd5) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == rx_valid));
  // R3
  pop_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_sel && !bus_wr && bus_addr == 3'd0 && !line_q[7] && rx_valid));
  // R5
  thr_clears_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd0 && !line_q[7]) |=> !tx_flag);
  // R6
  ier_tx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd1 && !line_q[7] && bus_wdata[1]) |=> tx_flag);
  // R6
  ier_tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd1 && !line_q[7] && !bus_wdata[1]) |=> !tx_flag);
  // R10
  mcr_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd4 && bus_wdata == 8'h1A) |=> modem_q == 8'h9A);
endmodule

bind serial_host_regs serial_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .line_q(line_q), .modem_q(modem_q), .tx_flag(tx_flag)
);

// File: tb/serial_host_regs_bench.sv
module serial_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_data = 0;
  logic rx_valid = 0;
  logic [7:0] bus_rdata, tx_data;
  logic rx_ready, tx_valid, irq;

  int checks = 0, fails = 0;

  // behavioural model state
  int m_en = 0, m_line = 0, m_modem = 0, m_lo = 0, m_hi = 0;
  bit m_rx = 0, m_tx = 0, m_rearm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_host_regs u_serial_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int expect_read(int a);
    bit dl = (m_line & 8'h80) != 0;
    case (a)
      0: return dl ? m_lo : (rx_valid ? int'(rx_data) : 0);
      1: return dl ? m_hi : m_en;
      2: return (m_rx || m_tx) ? 0 : 1;
      3: return m_line;
      4: return m_modem;
      5: return 8'h60 + (rx_valid ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic step(bit sel, bit w, int a, int d, string tag);
    bit dl, is_rd, is_wr;
    bus_sel = sel; bus_wr = w; bus_addr = 3'(a); bus_wdata = 8'(d);
    #1;
    dl = (m_line & 8'h80) != 0;
    is_rd = sel && !w;
    is_wr = sel && w;
    check(tag, "rdata", int'(bus_rdata), is_rd ? expect_read(a) : 0);
    check(tag, "rx_ready", int'(rx_ready), (is_rd && a == 0 && !dl && rx_valid) ? 1 : 0);
    check(tag, "tx_valid", int'(tx_valid), (is_wr && a == 0 && !dl) ? 1 : 0);
    if (tx_valid) check(tag, "tx_data", int'(tx_data), d);
    check("R11", "irq", int'(irq), (m_rx || m_tx) ? 1 : 0);
    @(posedge clk);
    // receive flag
    if (is_wr && a == 1 && !dl) m_rx = ((d & 1) != 0) && rx_valid;
    else if (is_rd && a == 0 && !dl) m_rx = 0;
    else if (rx_valid && (m_en & 1) != 0) m_rx = 1;
    // transmit flag
    if (is_wr && a == 1 && !dl) begin m_tx = (d & 2) != 0; m_rearm = 0; end
    else if (is_wr && a == 0 && !dl) begin m_tx = 0; m_rearm = (m_en & 2) != 0; end
    else begin if (m_rearm) m_tx = 1; m_rearm = 0; end
    // registers
    if (is_wr) begin
      if (a == 0 && dl) m_lo = d;
      if (a == 1 && dl) m_hi = d;
      if (a == 1 && !dl) m_en = d;
      if (a == 3) m_line = d;
      if (a == 4 && d == 8'h1A) m_modem = 8'h9A;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
  endtask
  task automatic wr_reg(int a, int d, string tag); step(1, 1, a, d, tag); endtask
  task automatic rd_reg(int a, string tag); step(1, 0, a, 0, tag); endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 8; a++) rd_reg(a, "R1");
    // R12 line control readback, R2 divisor bank
    wr_reg(3, 8'h83, "R12");
    rd_reg(3, "R12");
    wr_reg(0, 8'h0C, "R2");
    wr_reg(1, 8'h01, "R2");
    rx_valid = 1; rx_data = 8'hA5;
    rd_reg(0, "R2");
    rd_reg(1, "R2");
    rx_valid = 0;
    wr_reg(3, 8'h03, "R12");
    rd_reg(1, "R12");
    // R4 data with receive enable off: no flag
    rx_valid = 1; rx_data = 8'h31;
    idle(3, "R4");
    rd_reg(2, "R7");
    // R6 enabling receive with data present
    wr_reg(1, 8'h01, "R6");
    rd_reg(2, "R7");
    // R3 pop, R4 re-arm while data stays valid
    rd_reg(0, "R3");
    rx_data = 8'h32;
    idle(1, "R4");
    rd_reg(0, "R3");
    rx_valid = 0;
    idle(2, "R4");
    rd_reg(0, "R3");
    rd_reg(5, "R8");
    rx_valid = 1; rx_data = 8'h77;
    rd_reg(5, "R8");
    wr_reg(1, 8'h00, "R6");
    rx_valid = 0;
    idle(1, "R6");
    // R5 transmit with enable off then on
    wr_reg(0, 8'h41, "R5");
    idle(2, "R5");
    wr_reg(1, 8'h02, "R6");
    rd_reg(2, "R7");
    wr_reg(0, 8'h42, "R5");
    rd_reg(2, "R5");
    idle(1, "R5");
    rd_reg(2, "R7");
    // R6 cancel pending re-raise
    wr_reg(0, 8'h43, "R5");
    wr_reg(1, 8'h00, "R6");
    idle(3, "R6");
    rd_reg(2, "R7");
    // R9 ignored offsets
    wr_reg(7, 8'hFF, "R9");
    wr_reg(2, 8'hC7, "R9");
    rd_reg(6, "R9");
    rd_reg(7, "R9");
    rd_reg(1, "R9");
    rd_reg(3, "R9");
    rd_reg(2, "R9");
    // R10 modem control magic
    wr_reg(4, 8'h55, "R10");
    rd_reg(4, "R10");
    wr_reg(4, 8'h1A, "R10");
    rd_reg(4, "R10");
    wr_reg(4, 8'h00, "R10");
    rd_reg(4, "R10");
    idle(2, "R11");
    report();
  end
endmodule